// File: doc/BRIEF.md
# Harvested-Supply Power Mode Controller

This block is the digital power manager of a batteryless sensing tag whose only reserve is a storage capacitor. Three supervisor comparators report whether the stored supply is under the hard-reset level (1.6 V), under the retention level (1.9 V), and whether enough energy is banked to run the demodulator. The block synchronises and filters these flags and then runs one mode machine. That machine holds the core in reset, parks it in a RAM-retention mode, or lets it sleep until a packet-start detect wakes it. The packet-start detect needs neither the demodulator nor the receive clock. Once awake, the machine selects the fast (4 MHz) clock for receive, where the core performs clock and data recovery, or the slow (2 MHz) calibrated clock for transmit.

A second sequencer powers a sensor on request. It waits a programmable settling interval, then issues a one-cycle ADC start strobe. It removes sensor power when the ADC reports completion or when the supply collapses. No optional load is switched on while the tag is modulating its backscatter. A brown-out that interrupts a receive or transmit is reported to the core after it wakes again.

FSM states: `ST_RESET` (core held in reset), `ST_RETAIN` (RAM retention only), `ST_SLEEP` (core idle, clocks off), `ST_RX` (fast clock, demodulator), `ST_TX` (slow clock, modulating). Transitions:
- Any state to ST_RESET when the filtered hard flag is set.
- ST_RESET to ST_RETAIN when the hard flag clears but the retention flag is still set.
- ST_RESET to ST_SLEEP when both flags are clear.
- ST_SLEEP, ST_RX or ST_TX to ST_RETAIN when the retention flag is set (brown-out).
- ST_RETAIN to ST_SLEEP when the retention flag clears (recover).
- ST_SLEEP to ST_RX on a packet start while the energy flag is set (wake).
- ST_RX to ST_TX on a transmit start (reply). This has priority over the end of receive.
- ST_RX to ST_SLEEP on the end of receive.
- ST_TX to ST_SLEEP on the end of transmit.

Sensor sequencer states: `SN_IDLE`, `SN_SETTLE`, `SN_CONV`.

Top module: `tag_power_ctrl`

## Requirements
- R1: While the filtered below-1.6 V flag is set, `core_rst` is 1 and `retain_en`, `demod_en`, `clk_fast`, `clk_slow` and `sensor_en` are 0. This overrides every other condition and clears the abort flag.
- R2: While the filtered below-1.9 V flag is set and the below-1.6 V flag is clear, `retain_en` is 1 and the clocks, demodulator and sensor are off. When the flag clears, the block returns to sleep with all outputs 0.
- R3: Each supervisor input passes through two synchronising flops. A new level is accepted only after it has differed from the accepted level for DB_CYCLES consecutive cycles (default 4), so a shorter glitch changes no output. After reset the accepted levels are: below-1.6 V set, below-1.9 V set, energy clear.
- R4: In sleep, `pkt_start` wakes the core into receive only if the filtered energy flag is set. Otherwise it is ignored.
- R5: In receive, `clk_fast` is 1 and `demod_en` follows the filtered energy flag. `rx_done` returns the block to sleep.
- R6: `tx_start` during receive enters transmit, where only `clk_slow` is 1 and `demod_en` is 0. `tx_done` returns to sleep. `clk_fast` and `clk_slow` are never 1 together.
- R7: `sensor_en` never rises while transmitting or on the edge that enters transmit. A `sense_req` in that situation is dropped.
- R8: After `sensor_en` rises, `adc_start` pulses high for exactly one cycle, max(`settle_len`,1) cycles later.
- R9: `sensor_en` stays 1 until `adc_done` and falls on the next edge. It also falls on the edge that enters retention or reset.
- R10: A retention brown-out during receive or transmit sets an abort flag. `xfer_abort` is 1 in sleep after recovery, until the next wake clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_lo_hard | input | 1 | Supervisor: supply under 1.6 V (asynchronous) |
| sup_lo_ret | input | 1 | Supervisor: supply under 1.9 V (asynchronous) |
| sup_energy_ok | input | 1 | Supervisor: enough energy stored (asynchronous) |
| pkt_start | input | 1 | Packet-start detect, synchronous |
| rx_done | input | 1 | Core: receive finished |
| tx_start | input | 1 | Core: begin transmit |
| tx_done | input | 1 | Core: transmit finished |
| sense_req | input | 1 | Core: sensor sample request |
| settle_len | input | SETTLE_W | Sensor settling interval in cycles |
| adc_done | input | 1 | ADC: conversion finished |
| core_rst | output | 1 | Hard reset to the digital core |
| retain_en | output | 1 | RAM-retention low-power mode |
| demod_en | output | 1 | Demodulator enable |
| clk_fast | output | 1 | Select 4 MHz receive clock |
| clk_slow | output | 1 | Select 2 MHz transmit clock |
| sensor_en | output | 1 | Sensor power enable |
| adc_start | output | 1 | One-cycle ADC start strobe |
| xfer_abort | output | 1 | Last transfer was cut by brown-out |

## Verification
The checker holds on every cycle the quiet output sets of reset and retention and the exclusivity of the two clock selects. It also checks that the demodulator runs only with the fast clock, that receive is entered only with energy present, that the sensor never powers up during transmit, and that the ADC strobe is one cycle wide and issued only while the sensor is powered. The scenarios alone can show the debounce filtering of short glitches, the exact settling count including the zero case, the dropped request at the receive-to-transmit edge, and the abort flag surviving retention and clearing on the next wake.

// File: rtl/tag_pwr_pkg.sv
package tag_pwr_pkg;
    typedef enum logic [2:0] {
        ST_RESET  = 3'd0,
        ST_RETAIN = 3'd1,
        ST_SLEEP  = 3'd2,
        ST_RX     = 3'd3,
        ST_TX     = 3'd4
    } pwr_state_t;

    typedef enum logic [1:0] {
        SN_IDLE   = 2'd0,
        SN_SETTLE = 2'd1,
        SN_CONV   = 2'd2
    } sns_state_t;
endpackage

// File: rtl/tag_sup_filter.sv
module tag_sup_filter #(
    parameter int              N         = 3,
    parameter int              DB_CYCLES = 4,
    parameter logic [N-1:0]    RST_VAL   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    localparam int CNT_W = $clog2(DB_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DB_CYCLES - 1);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic             s1, s2;
        logic [CNT_W-1:0] cnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1      <= RST_VAL[g];
                s2      <= RST_VAL[g];
                cnt     <= '0;
                dout[g] <= RST_VAL[g];
            end else begin
                s1 <= din[g];
                s2 <= s1;
                if (s2 != dout[g]) begin
                    if (cnt == CNT_LAST) begin
                        dout[g] <= s2;
                        cnt     <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end else begin
                    cnt <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/tag_pwr_fsm.sv
module tag_pwr_fsm
    import tag_pwr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lo_hard,
    input  logic lo_ret,
    input  logic energy,
    input  logic pkt_start,
    input  logic rx_done,
    input  logic tx_start,
    input  logic tx_done,
    output logic core_rst,
    output logic retain_en,
    output logic demod_en,
    output logic clk_fast,
    output logic clk_slow,
    output logic xfer_abort,
    output logic load_grant,
    output logic load_kill
);
    pwr_state_t state, nxt;
    logic       abort_q;

    always_comb begin
        nxt = state;
        if (lo_hard) begin
            nxt = ST_RESET;
        end else begin
            unique case (state)
                ST_RESET:  nxt = lo_ret ? ST_RETAIN : ST_SLEEP;
                ST_RETAIN: if (!lo_ret) nxt = ST_SLEEP;
                ST_SLEEP: begin
                    if (lo_ret)                   nxt = ST_RETAIN;
                    else if (pkt_start && energy) nxt = ST_RX;
                end
                ST_RX: begin
                    if (lo_ret)        nxt = ST_RETAIN;
                    else if (tx_start) nxt = ST_TX;
                    else if (rx_done)  nxt = ST_SLEEP;
                end
                ST_TX: begin
                    if (lo_ret)       nxt = ST_RETAIN;
                    else if (tx_done) nxt = ST_SLEEP;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            abort_q <= 1'b0;
        end else if (nxt == ST_RESET) begin
            abort_q <= 1'b0;
        end else if ((state == ST_RX || state == ST_TX) && nxt == ST_RETAIN) begin
            abort_q <= 1'b1;
        end else if (state == ST_SLEEP && nxt == ST_RX) begin
            abort_q <= 1'b0;
        end
    end

    always_comb begin
        core_rst   = 1'b0;
        retain_en  = 1'b0;
        demod_en   = 1'b0;
        clk_fast   = 1'b0;
        clk_slow   = 1'b0;
        xfer_abort = 1'b0;
        unique case (state)
            ST_RESET:  core_rst   = 1'b1;
            ST_RETAIN: retain_en  = 1'b1;
            ST_SLEEP:  xfer_abort = abort_q;
            ST_RX: begin
                clk_fast = 1'b1;
                demod_en = energy;
            end
            ST_TX:     clk_slow   = 1'b1;
        endcase
    end

    assign load_grant = (nxt == ST_SLEEP) || (nxt == ST_RX);
    assign load_kill  = (nxt == ST_RESET) || (nxt == ST_RETAIN);
endmodule

// File: rtl/tag_sensor_seq.sv
module tag_sensor_seq
    import tag_pwr_pkg::*;
#(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                grant,
    input  logic                kill,
    input  logic                req,
    input  logic [SETTLE_W-1:0] settle_len,
    input  logic                adc_done,
    output logic                sensor_en,
    output logic                adc_start
);
    localparam int SUM_W = SETTLE_W + 1;

    sns_state_t          state, nxt;
    logic [SETTLE_W-1:0] cnt;
    logic                settled;

    assign settled = ({1'b0, cnt} + SUM_W'(1)) >= {1'b0, settle_len};

    always_comb begin
        nxt = state;
        if (kill) begin
            nxt = SN_IDLE;
        end else begin
            unique case (state)
                SN_IDLE:   if (grant && req) nxt = SN_SETTLE;
                SN_SETTLE: if (settled)      nxt = SN_CONV;
                SN_CONV:   if (adc_done)     nxt = SN_IDLE;
                default:                     nxt = SN_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= SN_IDLE;
            cnt       <= '0;
            adc_start <= 1'b0;
        end else begin
            state     <= nxt;
            adc_start <= (state == SN_SETTLE) && (nxt == SN_CONV);
            if (state == SN_SETTLE && nxt == SN_SETTLE) cnt <= cnt + 1'b1;
            else                                        cnt <= '0;
        end
    end

    assign sensor_en = (state != SN_IDLE);
endmodule

// File: rtl/tag_power_ctrl.sv
module tag_power_ctrl #(
    parameter int DB_CYCLES = 4,
    parameter int SETTLE_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sup_lo_hard,
    input  logic                sup_lo_ret,
    input  logic                sup_energy_ok,
    input  logic                pkt_start,
    input  logic                rx_done,
    input  logic                tx_start,
    input  logic                tx_done,
    input  logic                sense_req,
    input  logic [SETTLE_W-1:0] settle_len,
    input  logic                adc_done,
    output logic                core_rst,
    output logic                retain_en,
    output logic                demod_en,
    output logic                clk_fast,
    output logic                clk_slow,
    output logic                sensor_en,
    output logic                adc_start,
    output logic                xfer_abort
);
    localparam int NSUP = 3;
    localparam logic [NSUP-1:0] SUP_RST = 3'b011;

    logic [NSUP-1:0] sup_db;
    logic            lo_hard_db, lo_ret_db, energy_db;
    logic            load_grant, load_kill;

    tag_sup_filter #(
        .N         (NSUP),
        .DB_CYCLES (DB_CYCLES),
        .RST_VAL   (SUP_RST)
    ) filt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sup_energy_ok, sup_lo_ret, sup_lo_hard}),
        .dout  (sup_db)
    );

    assign lo_hard_db = sup_db[0];
    assign lo_ret_db  = sup_db[1];
    assign energy_db  = sup_db[2];

    tag_pwr_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lo_hard    (lo_hard_db),
        .lo_ret     (lo_ret_db),
        .energy     (energy_db),
        .pkt_start  (pkt_start),
        .rx_done    (rx_done),
        .tx_start   (tx_start),
        .tx_done    (tx_done),
        .core_rst   (core_rst),
        .retain_en  (retain_en),
        .demod_en   (demod_en),
        .clk_fast   (clk_fast),
        .clk_slow   (clk_slow),
        .xfer_abort (xfer_abort),
        .load_grant (load_grant),
        .load_kill  (load_kill)
    );

    tag_sensor_seq #(
        .SETTLE_W (SETTLE_W)
    ) sns_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant      (load_grant),
        .kill       (load_kill),
        .req        (sense_req),
        .settle_len (settle_len),
        .adc_done   (adc_done),
        .sensor_en  (sensor_en),
        .adc_start  (adc_start)
    );
endmodule

// File: rtl/tag_power_ctrl_chk.sv
module tag_power_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic core_rst,
    input logic retain_en,
    input logic demod_en,
    input logic clk_fast,
    input logic clk_slow,
    input logic sensor_en,
    input logic adc_start,
    input logic xfer_abort,
    input logic energy_db
);
    AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> !(retain_en || demod_en || clk_fast || clk_slow || sensor_en)); // R1
    AST_RET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        retain_en |-> !(demod_en || clk_fast || clk_slow || sensor_en)); // R2
    AST_WAKE_ENERGY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_fast) |-> $past(energy_db)); // R4
    AST_DEMOD_IN_RX: assert property (@(posedge clk) disable iff (!rst_n)
        demod_en |-> clk_fast); // R5
    AST_CLK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(clk_fast && clk_slow)); // R6
    AST_NO_LOAD_TX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sensor_en) |-> !clk_slow); // R7
    AST_ADC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start); // R8
    AST_ADC_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> sensor_en); // R8
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_abort |-> !(clk_fast || clk_slow || retain_en || core_rst)); // R10
endmodule

bind tag_power_ctrl tag_power_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_rst   (core_rst),
    .retain_en  (retain_en),
    .demod_en   (demod_en),
    .clk_fast   (clk_fast),
    .clk_slow   (clk_slow),
    .sensor_en  (sensor_en),
    .adc_start  (adc_start),
    .xfer_abort (xfer_abort),
    .energy_db  (energy_db)
);

// File: tb/tag_power_ctrl_tb_top.sv
module tag_power_ctrl_tb_top;
    localparam int SETTLE_W = 8;
    localparam int NV = 19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hard = 1'b1, ret = 1'b1, en = 1'b0;
    logic pkt = 1'b0, rxd = 1'b0, txs = 1'b0, txd = 1'b0, sreq = 1'b0, adone = 1'b0;
    logic [SETTLE_W-1:0] settle = 8'd5;
    logic core_rst, retain_en, demod_en, clk_fast, clk_slow, sensor_en, adc_start, xfer_abort;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    tag_power_ctrl #(.DB_CYCLES(4), .SETTLE_W(SETTLE_W)) dut_i (
        .clk (clk), .rst_n (rst_n),
        .sup_lo_hard (hard), .sup_lo_ret (ret), .sup_energy_ok (en),
        .pkt_start (pkt), .rx_done (rxd), .tx_start (txs), .tx_done (txd),
        .sense_req (sreq), .settle_len (settle), .adc_done (adone),
        .core_rst (core_rst), .retain_en (retain_en), .demod_en (demod_en),
        .clk_fast (clk_fast), .clk_slow (clk_slow), .sensor_en (sensor_en),
        .adc_start (adc_start), .xfer_abort (xfer_abort)
    );

    // inputs {hard,ret,en,pkt,rxd,txs,txd,sreq}, wait, expected
    // {core_rst,retain_en,demod_en,clk_fast,clk_slow,xfer_abort,sensor_en}, tag
    localparam logic [26:0] VEC [NV] = '{
        {8'b1100_0000, 8'd4,  7'b1000000, 4'd1 },  // R1 reset state
        {8'b0100_0000, 8'd12, 7'b0100000, 4'd2 },  // R2 retention
        {8'b0000_0000, 8'd12, 7'b0000000, 4'd2 },  // R2 recover to sleep
        {8'b0001_0000, 8'd6,  7'b0000000, 4'd4 },  // R4 no energy, no wake
        {8'b0010_0000, 8'd12, 7'b0000000, 4'd3 },  // R3 energy accepted
        {8'b0011_0000, 8'd3,  7'b0011000, 4'd4 },  // R4 wake
        {8'b0010_1000, 8'd3,  7'b0000000, 4'd5 },  // R5 rx end
        {8'b0011_0000, 8'd3,  7'b0011000, 4'd4 },  // R4 wake again
        {8'b0010_0100, 8'd3,  7'b0000100, 4'd6 },  // R6 reply
        {8'b0010_0001, 8'd6,  7'b0000100, 4'd7 },  // R7 sense in tx dropped
        {8'b0010_0010, 8'd3,  7'b0000000, 4'd6 },  // R6 tx end, R7 still off
        {8'b0011_0000, 8'd3,  7'b0011000, 4'd4 },  // R4 wake
        {8'b0110_0000, 8'd12, 7'b0100000, 4'd10},  // R10 brown-out in rx
        {8'b0010_0000, 8'd12, 7'b0000010, 4'd10},  // R10 abort reported
        {8'b0011_0000, 8'd3,  7'b0011000, 4'd10},  // R10 cleared on wake
        {8'b0000_0000, 8'd12, 7'b0001000, 4'd5 },  // R5 demod follows energy
        {8'b0010_0000, 8'd12, 7'b0011000, 4'd5 },  // R5 demod back on
        {8'b1110_0000, 8'd12, 7'b1000000, 4'd1 },  // R1 hard reset from rx
        {8'b0010_0000, 8'd12, 7'b0000000, 4'd1 }   // R1 release to sleep
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // sensor timing monitor, sampled at the falling edge
    logic prev_sens = 1'b0;
    int   gap = 0, gap_at_adc = -1, adc_hi = 0;
    always @(negedge clk) begin
        if (sensor_en && !prev_sens) begin
            gap = 0; adc_hi = 0; gap_at_adc = -1;
        end else if (sensor_en) begin
            gap++;
        end
        if (adc_start) begin
            adc_hi++;
            gap_at_adc = gap;
        end
        prev_sens = sensor_en;
    end

    task automatic run_sense(input logic [SETTLE_W-1:0] len, input int exp_gap, input string tag);
        settle = len;
        @(negedge clk); sreq = 1'b1;
        @(negedge clk); sreq = 1'b0;
        for (int k = 0; k < 40 && gap_at_adc < 0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk({tag, " settle gap"}, gap_at_adc, exp_gap);
        chk("R8 strobe width", adc_hi, 1);
        chk("R9 held until done", int'(sensor_en), 1);
        adone = 1'b1;
        @(negedge clk); adone = 1'b0;
        chk("R9 off after done", int'(sensor_en), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            {hard, ret, en, pkt, rxd, txs, txd, sreq} = VEC[i][26:19];
            repeat (int'(VEC[i][18:11])) @(negedge clk);
            chk($sformatf("R%0d vector %0d", int'(VEC[i][3:0]), i),
                int'({core_rst, retain_en, demod_en, clk_fast, clk_slow, xfer_abort, sensor_en}),
                int'(VEC[i][10:4]));
        end
        pkt = 1'b0; rxd = 1'b0;

        // R3: two-cycle glitch on retention flag is filtered
        begin
            int seen = 0;
            @(negedge clk); ret = 1'b1;
            repeat (2) @(negedge clk);
            ret = 1'b0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (retain_en) seen++;
            end
            chk("R3 glitch ignored", seen, 0);
        end

        // R8/R9: settle timing
        run_sense(8'd5, 5, "R8");
        run_sense(8'd0, 1, "R8 zero");

        // R9: brown-out removes sensor power mid-settle
        settle = 8'd40;
        @(negedge clk); sreq = 1'b1;
        @(negedge clk); sreq = 1'b0; ret = 1'b1;
        repeat (12) @(negedge clk);
        chk("R9 killed by retention", int'({retain_en, sensor_en}), 2);
        ret = 1'b0;
        repeat (12) @(negedge clk);
        chk("R9 stays off after recover", int'(sensor_en), 0);

        // R7: request on the receive-to-transmit edge is dropped
        pkt = 1'b1;
        @(negedge clk); pkt = 1'b0;
        @(negedge clk); txs = 1'b1; sreq = 1'b1;
        @(negedge clk); txs = 1'b0; sreq = 1'b0;
        chk("R7 tx entry no load", int'({clk_slow, sensor_en}), 2);
        txd = 1'b1;
        @(negedge clk); txd = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 sleep no load", int'({clk_slow, sensor_en}), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual expired expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule